// File: doc/BRIEF.md
# External Interrupt Edge/Level Unit

This unit turns a set of external input pins into per-channel sticky interrupt flags and a wake-up request for the power controller. Each channel has a pin-select mask that picks which pins feed it, a sensitivity bit (level or edge) and a polarity bit (low/falling or high/rising). After a two-flop synchronizer, the selected pins of a channel are reduced to one channel signal. Low-active level channels use a wired-AND, so any selected pin pulled low asserts the channel. High-active level channels use an OR. Edge channels follow only the lowest-indexed selected pin.

Software reads and writes the configuration through a word-wide port with one address per register. It clears a flag by writing one to its bit. In level mode the flag re-sets at once while the channel input is still active, so a clear written then has no lasting effect. A channel with its wake bit set emits a one-cycle wake pulse when its flag sets. The unit also holds a power-down block signal for as long as any wake-enabled flag remains set.

Top module: `eirq_unit`

## Requirements
- R1: After reset all flags, sensitivity, polarity, wake and pin-select registers read 0, `irq_o` is 0, and `wake_req_o` and `pd_block_o` are low.
- R2: Register addresses are 0 flags, 1 sensitivity (bit set = edge), 2 polarity (bit set = high/rising), 3 wake enable, and 4+c the pin-select mask of channel c. Bit c of registers 0–3 belongs to channel c. `rdata_o` returns the register addressed on the previous clock edge.
- R3: In level mode a flag is set while its channel input is active. A clear written in that state leaves the flag at 1. A clear written while the input is inactive drops the flag to 0.
- R4: A low-active level channel is active when any of its selected pins is low.
- R5: A high-active level channel is active when any of its selected pins is high.
- R6: An edge channel sets its flag on a rising (polarity 1) or falling (polarity 0) transition of its lowest-indexed selected pin. Transitions on its other selected pins are ignored.
- R7: Writing 1 to a flag bit of an edge channel clears it. Writing 0 leaves it unchanged.
- R8: A channel with an empty pin-select mask never sets its flag.
- R9: A pin change shows in `irq_o` on the third rising clock edge after it, and not earlier.
- R10: `wake_req_o` pulses high for exactly one cycle, in the same cycle the flag of a wake-enabled channel first reads 1. A channel without wake enable never drives it.
- R11: `pd_block_o` is high exactly while at least one wake-enabled flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| pin_i | input | NPIN | Asynchronous external interrupt pins |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | AW | Register address for read and write |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data, one cycle after the address |
| irq_o | output | NCH | Sticky interrupt flags |
| wake_req_o | output | 1 | One-cycle wake-up pulse |
| pd_block_o | output | 1 | Power-down entry must be refused |

## Verification
A pin change passes two synchronizer flops and the flag register, so a flag is due on the third rising edge after the pin moves. The bench probes one cycle before that edge and on it, then leaves four cycles before it judges a flag in the sweeps. A register write lands on the edge between the two falling edges that frame it, so a clear-write check samples on the following falling edge. A read returns data one edge after the address. The wake pulse is sampled on the same edge as its flag and again one cycle later.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  localparam int unsigned REG_FLAG = 0;
  localparam int unsigned REG_MODE = 1;
  localparam int unsigned REG_POL  = 2;
  localparam int unsigned REG_WAKE = 3;
  localparam int unsigned REG_SEL0 = 4;
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/eirq_combine.sv
module eirq_combine #(
  parameter int NPIN = 4
) (
  input  logic [NPIN-1:0] pins_i,
  input  logic [NPIN-1:0] sel_i,
  input  logic            edge_i,
  input  logic            high_i,
  output logic            chan_o
);
  logic and_v, or_v, pick, found;

  always_comb begin
    and_v = &(pins_i | ~sel_i);
    or_v  = |(pins_i & sel_i);
    pick  = ~high_i;
    found = 1'b0;
    for (int i = 0; i < NPIN; i++) begin
      if (sel_i[i] && !found) begin
        pick  = pins_i[i];
        found = 1'b1;
      end
    end
    if (edge_i)      chan_o = pick;
    else if (high_i) chan_o = or_v;
    else             chan_o = and_v;
  end
endmodule

// File: rtl/eirq_chan.sv
module eirq_chan (
  input  logic clk_i,
  input  logic rst_i,
  input  logic chan_i,
  input  logic edge_i,
  input  logic high_i,
  input  logic clr_i,
  output logic flag_o,
  output logic flag_next_o,
  output logic active_o
);
  logic prev_q, flag_q, hit;

  assign active_o = (chan_i == high_i);

  always_comb begin
    if (edge_i) hit = active_o && (chan_i != prev_q);
    else        hit = active_o;
    flag_next_o = hit | (flag_q & ~clr_i);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= chan_i;
      flag_q <= flag_next_o;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/eirq_unit.sv
module eirq_unit
  import eirq_pkg::*;
#(
  parameter  int NCH  = 4,
  parameter  int NPIN = 6,
  parameter  int DW   = 32,
  localparam int AW   = $clog2(REG_SEL0 + NCH)
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic [NPIN-1:0] pin_i,
  input  logic            wr_en_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  output logic [NCH-1:0]  irq_o,
  output logic            wake_req_o,
  output logic            pd_block_o
);
  logic [NPIN-1:0] pin_s;
  logic [NCH-1:0]  mode_q, pol_q, wake_q;
  logic [NCH-1:0]  flag_q, flag_d, act_w, clr_w;
  logic [NPIN-1:0] sel_q [NCH];
  logic            wake_q_pulse;
  logic            wr_flag;

  eirq_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .d_i   (pin_i),
    .q_o   (pin_s)
  );

  assign wr_flag = wr_en_i && (addr_i == AW'(REG_FLAG));
  assign clr_w   = wr_flag ? wdata_i[NCH-1:0] : '0;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      mode_q <= '0;
      pol_q  <= '0;
      wake_q <= '0;
      for (int c = 0; c < NCH; c++) sel_q[c] <= '0;
    end else if (wr_en_i) begin
      if (addr_i == AW'(REG_MODE)) mode_q <= wdata_i[NCH-1:0];
      if (addr_i == AW'(REG_POL))  pol_q  <= wdata_i[NCH-1:0];
      if (addr_i == AW'(REG_WAKE)) wake_q <= wdata_i[NCH-1:0];
      for (int c = 0; c < NCH; c++)
        if (addr_i == AW'(REG_SEL0 + c)) sel_q[c] <= wdata_i[NPIN-1:0];
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic chan_w;
    eirq_combine #(.NPIN(NPIN)) u_comb (
      .pins_i (pin_s),
      .sel_i  (sel_q[c]),
      .edge_i (mode_q[c]),
      .high_i (pol_q[c]),
      .chan_o (chan_w)
    );
    eirq_chan u_chan (
      .clk_i       (clk_i),
      .rst_i       (rst_i),
      .chan_i      (chan_w),
      .edge_i      (mode_q[c]),
      .high_i      (pol_q[c]),
      .clr_i       (clr_w[c]),
      .flag_o      (flag_q[c]),
      .flag_next_o (flag_d[c]),
      .active_o    (act_w[c])
    );
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) wake_q_pulse <= 1'b0;
    else       wake_q_pulse <= |(flag_d & ~flag_q & wake_q);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rdata_o <= '0;
    end else begin
      rdata_o <= '0;
      if (addr_i == AW'(REG_FLAG)) rdata_o[NCH-1:0] <= flag_q;
      if (addr_i == AW'(REG_MODE)) rdata_o[NCH-1:0] <= mode_q;
      if (addr_i == AW'(REG_POL))  rdata_o[NCH-1:0] <= pol_q;
      if (addr_i == AW'(REG_WAKE)) rdata_o[NCH-1:0] <= wake_q;
      for (int c = 0; c < NCH; c++)
        if (addr_i == AW'(REG_SEL0 + c)) rdata_o[NPIN-1:0] <= sel_q[c];
    end
  end

  assign irq_o      = flag_q;
  assign wake_req_o = wake_q_pulse;
  assign pd_block_o = |(flag_q & wake_q);
endmodule

// File: rtl/eirq_unit_chk.sv
module eirq_unit_chk #(
  parameter int NCH  = 4,
  parameter int NPIN = 6,
  parameter int DW   = 32,
  parameter int AW   = 3
) (
  input logic           clk_i,
  input logic           rst_i,
  input logic           wr_en_i,
  input logic [AW-1:0]  addr_i,
  input logic [DW-1:0]  wdata_i,
  input logic [DW-1:0]  rdata_o,
  input logic [NCH-1:0] irq_o,
  input logic           wake_req_o,
  input logic [NCH-1:0] mode_q,
  input logic [NCH-1:0] act_w
);
  for (genvar c = 0; c < NCH; c++) begin : g_a
    // R3
    lvl_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (!mode_q[c] && act_w[c]) |=> irq_o[c]);
    // R7
    clear_source_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      $fell(irq_o[c]) |-> $past(wr_en_i && addr_i == '0 && wdata_i[c]));
  end

  // R10
  wake_flag_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    wake_req_o |-> (irq_o != '0));

  // R10
  wake_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    wake_req_o |=> !wake_req_o);

  // R2
  flag_read_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(addr_i) == '0) |-> (rdata_o[NCH-1:0] == $past(irq_o)));

  // R1
  reset_clear_chk: assert property (@(posedge clk_i)
    rst_i |=> (irq_o == '0 && !wake_req_o));
endmodule

bind eirq_unit eirq_unit_chk #(
  .NCH(NCH), .NPIN(NPIN), .DW(DW), .AW($clog2(eirq_pkg::REG_SEL0 + NCH))
) u_chk (
  .clk_i      (clk_i),
  .rst_i      (rst_i),
  .wr_en_i    (wr_en_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .irq_o      (irq_o),
  .wake_req_o (wake_req_o),
  .mode_q     (mode_q),
  .act_w      (act_w)
);

// File: tb/eirq_unit_bench.sv
`timescale 1ns/1ps
module eirq_unit_bench;
  localparam int NCH  = 4;
  localparam int NPIN = 4;
  localparam int DW   = 32;
  localparam int AW   = 3;

  logic            clk = 0;
  logic            rst;
  logic [NPIN-1:0] pins;
  logic            wr_en;
  logic [AW-1:0]   addr;
  logic [DW-1:0]   wdata;
  logic [DW-1:0]   rdata;
  logic [NCH-1:0]  irq;
  logic            wake_req, pd_block;

  int total = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  eirq_unit #(.NCH(NCH), .NPIN(NPIN), .DW(DW)) u_eirq_unit (
    .clk_i(clk), .rst_i(rst), .pin_i(pins), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .wake_req_o(wake_req),
    .pd_block_o(pd_block)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; addr = AW'(a); wdata = d;
    @(negedge clk);
    wr_en = 0; wdata = '0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    addr = AW'(a);
    @(negedge clk);
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit lvl_active(input logic [3:0] p, input logic [3:0] s, input bit high);
    if (high) return (p & s) != 4'd0;
    return (p & s) != s;
  endfunction

  function automatic bit edge_hit(input logic [3:0] a, input logic [3:0] b,
                                  input logic [3:0] s, input bit high);
    for (int i = 0; i < 4; i++)
      if (s[i]) return high ? (!a[i] && b[i]) : (a[i] && !b[i]);
    return 0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst = 1; pins = '0; wr_en = 0; addr = '0; wdata = '0;
    idle(3);
    @(negedge clk); rst = 0;

    // R1 reset state
    check("R1 irq", irq, 0);
    check("R1 wake_req", wake_req, 0);
    check("R1 pd_block", pd_block, 0);
    for (int a = 0; a < 8; a++) begin
      rd(a, v);
      check($sformatf("R1 reg %0d", a), v, 0);
    end

    // R2 readback of configuration registers
    wr(5, 32'h9); rd(5, v); check("R2 sel1 readback", v, 32'h9);
    wr(1, 32'ha); rd(1, v); check("R2 mode readback", v, 32'ha);
    wr(2, 32'h5); rd(2, v); check("R2 pol readback", v, 32'h5);
    wr(3, 32'h3); rd(3, v); check("R2 wake readback", v, 32'h3);
    wr(1, 0); wr(2, 0); wr(3, 0); wr(5, 0);

    // R9 latency, R10 wake pulse, R11 power-down block: ch1 level high on pin 2
    wr(2, 32'h2); wr(5, 32'h4); wr(3, 32'h2);
    idle(4); wr(0, 32'hf); idle(1);
    check("R9 idle flag", irq, 0);
    @(negedge clk); pins = 4'b0100;
    @(posedge clk); @(posedge clk); #1;
    check("R9 flag not yet", irq[1], 0);
    check("R10 no early wake", wake_req, 0);
    @(posedge clk); #1;
    check("R9 flag on third edge", irq[1], 1);
    check("R10 wake pulse", wake_req, 1);
    check("R11 block high", pd_block, 1);
    @(posedge clk); #1;
    check("R10 wake one cycle", wake_req, 0);
    check("R11 block held", pd_block, 1);
    rd(0, v); check("R2 flag readback", v, 32'h2);
    wr(0, 32'h2); idle(1);
    check("R3 clear ignored while active", irq[1], 1);
    @(negedge clk); pins = 0; idle(4);
    wr(0, 32'h2); idle(1);
    check("R3 clear when inactive", irq[1], 0);
    check("R11 block low", pd_block, 0);
    // R10: no wake when wake disabled
    wr(3, 0);
    @(negedge clk); pins = 4'b0100;
    idle(4);
    check("R10 flag set without wake", irq[1], 1);
    check("R10 no wake when disabled", wake_req, 0);
    check("R11 no block when disabled", pd_block, 0);
    @(negedge clk); pins = 0; idle(4); wr(0, 32'hf); wr(5, 0); wr(2, 0);
    idle(4); wr(0, 32'hf);

    // R7 edge clear, write zero no effect: ch0 rising on pin 0
    wr(1, 32'h1); wr(2, 32'h1); wr(4, 32'h1); idle(4); wr(0, 32'h1); idle(1);
    @(negedge clk); pins = 4'b0001; idle(4);
    check("R6 rising edge", irq[0], 1);
    wr(0, 32'h0); idle(1);
    check("R7 write zero keeps flag", irq[0], 1);
    wr(0, 32'h1); idle(1);
    check("R7 write one clears while pin high", irq[0], 0);
    @(negedge clk); pins = 0;

    // Level sweep on ch0: R3 R4 R5 R8
    wr(1, 0);
    for (int pol = 0; pol < 2; pol++) begin
      wr(2, pol);
      for (int s = 0; s < 16; s++) begin
        wr(4, s);
        for (int p = 0; p < 16; p++) begin
          bit e;
          @(negedge clk); pins = 4'(p);
          idle(4);
          wr(0, 32'h1); idle(1);
          e = lvl_active(4'(p), 4'(s), pol[0]);
          if (s == 0)
            check("R8 empty mask level", irq[0], 0);
          else if (pol == 1)
            check($sformatf("R5 R3 sel %0h pins %0h", s, p), irq[0], e);
          else
            check($sformatf("R4 R3 sel %0h pins %0h", s, p), irq[0], e);
        end
      end
    end

    // Edge sweep on ch0: R6 R7 R8
    wr(1, 32'h1);
    for (int pol = 0; pol < 2; pol++) begin
      wr(2, pol);
      for (int s = 0; s < 16; s++) begin
        wr(4, s);
        for (int a = 0; a < 16; a++) begin
          for (int k = 0; k < 5; k++) begin
            logic [3:0] b;
            b = (k == 4) ? 4'(a) : (4'(a) ^ 4'(1 << k));
            @(negedge clk); pins = 4'(a);
            idle(4);
            wr(0, 32'h1); idle(1);
            check("R7 edge flag cleared", irq[0], 0);
            @(negedge clk); pins = b;
            idle(4);
            if (s == 0)
              check("R8 empty mask edge", irq[0], 0);
            else
              check($sformatf("R6 sel %0h %0h->%0h pol %0d", s, a, b, pol),
                    irq[0], edge_hit(4'(a), b, 4'(s), pol[0]));
          end
        end
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule